// File: doc/BRIEF.md
# Early-Terminating Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor and returns a 32-bit quotient. Each operation selects signed or unsigned operands. A one-cycle `start` pulse launches an operation. `busy` stays high while it runs, and a one-cycle `done` pulse marks the result. The quotient then holds until the next result replaces it.

Fixed-length dividers always run every bit step. This divider first measures the significant-bit length of both operand magnitudes. It aligns the divisor to the dividend and runs only as many steps as the length difference requires. Each cycle retires `STEPS` quotient bits, three by default. Operands of similar length therefore finish quickly, and the worst case for 32-bit operands is twelve cycles.

Signed operands are reduced to magnitudes before the division starts. The quotient is negated afterwards when the two signs differ. A zero divisor, or a divisor larger than the dividend, skips the loop and yields zero at the minimum latency. The magnitude of the remainder stays inside the block.

Top module: `int_divider`

## Requirements
- R1: With `is_signed` low, both operands are read as unsigned, and `quotient` equals the dividend divided by the divisor, rounded down.
- R2: With `is_signed` high, both operands are read as two's complement. The quotient is rounded toward zero, and it is negative when exactly one operand is negative.
- R3: A signed division of 0x80000000 by 0xFFFFFFFF (-1) returns 0x80000000 with normal timing and no other effect.
- R4: A zero divisor gives a quotient of 0 with a latency of 2 cycles, in both signed and unsigned mode.
- R5: A divisor magnitude larger than the dividend magnitude gives a quotient of 0 with a latency of 2 cycles.
- R6: In all other cases the latency is 1 + ceil((La - Lb + 1) / 3) cycles. La and Lb are the bit lengths of the dividend and divisor magnitudes, where bit length is the index of the highest set bit plus one. Latency counts rising edges from the edge that samples `start` to the edge that raises `done`, so it ranges from 2 to 12.
- R7: `start` is accepted only while `busy` is low. `busy` rises on the edge that accepts `start` and falls on the edge that raises `done`. A `start` seen while `busy` is high is ignored and does not change the result of the running operation.
- R8: `done` is high for exactly one cycle per accepted operation. `quotient` changes only on the edge that raises `done` and holds its value otherwise.
- R9: While reset is applied and right after it, `busy`, `done` and `quotient` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, sampled while idle |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend |
| divisor | input | 32 | Divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 32 | Quotient, held until the next result |

## Verification
The bench builds the divider with its default parameters: 32-bit width and three quotient bits per cycle. These values give bit-length differences of 0 to 31 and therefore the full latency range of 2 to 12 cycles. Directed cases cover that range, both sign combinations, the zero-divisor and small-dividend shortcuts, and the single overflowing signed case. Pseudo-random pairs with widely spread bit lengths then compare quotient and latency against values the bench computes itself. A `start` issued while busy is also checked to leave the running result unchanged.

// File: rtl/int_divider.sv
module int_divider #(
  parameter int WIDTH = 32,
  parameter int STEPS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient
);
  localparam int DW = 2 * WIDTH;
  localparam int LW = $clog2(WIDTH + 1);
  localparam int CW = $clog2(WIDTH / STEPS + 2);

  function automatic logic [LW-1:0] bit_len(input logic [WIDTH-1:0] v);
    bit_len = '0;
    for (int i = 0; i < WIDTH; i++)
      if (v[i]) bit_len = LW'(i + 1);
  endfunction

  logic             a_neg, b_neg, trivial;
  logic [WIDTH-1:0] a_mag, b_mag;
  logic [CW-1:0]    k_start;
  logic [DW-1:0]    dv_start;
  int               d_i, k_i, s_i;

  assign a_neg   = is_signed & dividend[WIDTH-1];
  assign b_neg   = is_signed & divisor[WIDTH-1];
  assign a_mag   = a_neg ? (~dividend + 1'b1) : dividend;
  assign b_mag   = b_neg ? (~divisor + 1'b1) : divisor;
  assign trivial = (b_mag == '0) || (b_mag > a_mag);

  always_comb begin
    d_i = int'(bit_len(a_mag)) - int'(bit_len(b_mag));
    k_i = trivial ? 1 : (d_i + STEPS) / STEPS;
    s_i = STEPS * k_i - 1;
    k_start  = CW'(k_i);
    dv_start = trivial ? '1 : (DW'(b_mag) << s_i);
  end

  logic             busy_q, done_q, neg_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] rem_q, quo_q, qout_q, bmag_q;
  logic [DW-1:0]    dv_q;

  logic [WIDTH-1:0] r_nx, q_nx;
  logic [DW-1:0]    dv_nx;
  logic             qbit;

  always_comb begin
    r_nx  = rem_q;
    q_nx  = quo_q;
    dv_nx = dv_q;
    for (int j = 0; j < STEPS; j++) begin
      qbit = ({{WIDTH{1'b0}}, r_nx} >= dv_nx);
      if (qbit) r_nx = r_nx - dv_nx[WIDTH-1:0];
      q_nx  = {q_nx[WIDTH-2:0], qbit};
      dv_nx = dv_nx >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      qout_q <= '0;
      bmag_q <= '0;
      dv_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          cnt_q  <= k_start;
          rem_q  <= a_mag;
          dv_q   <= dv_start;
          quo_q  <= '0;
          neg_q  <= a_neg ^ b_neg;
          bmag_q <= b_mag;
        end
      end else if (cnt_q != '0) begin
        rem_q <= r_nx;
        quo_q <= q_nx;
        dv_q  <= dv_nx;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        qout_q <= neg_q ? (~quo_q + 1'b1) : quo_q;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = qout_q;
endmodule

// File: rtl/int_divider_chk.sv
module int_divider_chk #(
  parameter int WIDTH = 32,
  parameter int STEPS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] div_mag,
  input logic [WIDTH-1:0] rem_mag
);
  localparam int MAXLAT = 1 + (WIDTH + STEPS - 1) / STEPS;

  logic [7:0] lat_c;
  always_ff @(posedge clk) begin
    if (!rst_n) lat_c <= '0;
    else if (start && !busy) lat_c <= '0;
    else if (busy) lat_c <= lat_c + 1'b1;
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_q_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quotient) |-> done);
  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_c >= 8'd2 && lat_c <= 8'(MAXLAT)));
  assert_zero_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_mag == '0) |-> quotient == '0);
  assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_mag != '0) |-> rem_mag < div_mag);
endmodule

bind int_divider int_divider_chk #(.WIDTH(WIDTH), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .div_mag(bmag_q), .rem_mag(rem_q)
);

// File: tb/tb_int_divider.sv
module tb_int_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done;
  logic [31:0] quotient;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  int_divider dut (.*);

  logic [31:0] exp_q[$];
  int          exp_lat[$];
  int          exp_cyc[$];
  string       exp_tag[$];
  string       lat_tag[$];

  function automatic int blen(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input bit s);
    dividend = a; divisor = b; is_signed = s; start = 1'b1;
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input bit s, input string tag);
    logic [31:0] am, bm, q;
    int lat;
    @(negedge clk);
    while (busy) @(negedge clk);
    am = (s && a[31]) ? -a : a;
    bm = (s && b[31]) ? -b : b;
    if (b == 0) q = 0;
    else if (!s) q = a / b;
    else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) q = 32'h8000_0000;
    else q = $signed(a) / $signed(b);
    if (bm == 0 || bm > am) lat = 2;
    else lat = 1 + (blen(am) - blen(bm) + 3) / 3;
    drive(a, b, s);
    exp_q.push_back(q);
    exp_lat.push_back(lat);
    exp_cyc.push_back(cyc);
    exp_tag.push_back(tag);
    lat_tag.push_back((tag == "R4" || tag == "R5") ? tag : "R6");
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", {31'b0, busy}, 32'd1);
  endtask

  logic        prev_done = 1'b0;
  logic [31:0] last_q = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) chk(done == 1'b0, "R8 done pulse width", {31'b0, done}, 32'd0);
      if (!done) chk(quotient == last_q, "R8 quotient hold", quotient, last_q);
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", quotient, 32'd0);
        end else begin
          logic [31:0] q;
          int lat, c;
          string t, lt;
          q = exp_q.pop_front(); lat = exp_lat.pop_front();
          c = exp_cyc.pop_front(); t = exp_tag.pop_front(); lt = lat_tag.pop_front();
          chk(quotient == q, {t, " quotient"}, quotient, q);
          chk(cyc - c - 1 == lat, {lt, " latency"}, 32'(cyc - c - 1), 32'(lat));
        end
        last_q = quotient;
      end
      prev_done = done;
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && quotient == 0, "R9 reset state", quotient, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && quotient == 0, "R9 after reset", quotient, 32'd0);

    issue(32'd100, 32'd7, 0, "R1");
    issue(32'hFFFF_FFFF, 32'd1, 0, "R1");
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R1");
    issue(32'd12345678, 32'h1234, 0, "R1");
    issue(32'd7, 32'd7, 0, "R1");
    issue(32'h8000_0000, 32'd3, 0, "R1");
    issue(-32'd100, 32'd7, 1, "R2");
    issue(32'd100, -32'd7, 1, "R2");
    issue(-32'd100, -32'd7, 1, "R2");
    issue(32'h8000_0000, 32'd1, 1, "R2");
    issue(32'h8000_0000, 32'hFFFF_FFFF, 1, "R3");
    issue(32'd7, 32'd0, 1, "R4");
    issue(32'd0, 32'd0, 0, "R4");
    issue(32'hFFFF_FFFF, 32'd0, 0, "R4");
    issue(32'd3, 32'd5, 0, "R5");
    issue(-32'd3, 32'd5, 1, "R5");
    issue(32'd5, 32'h8000_0000, 1, "R5");
    issue(32'h4000_0000, 32'd2, 0, "R6");
    issue(32'd1, 32'd1, 1, "R6");

    issue(32'd1000, 32'd3, 0, "R7");
    drive(32'd9, 32'd0, 1);
    @(negedge clk);
    start = 1'b0;

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      a = lfsr >> lfsr[4:0];
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      b = lfsr >> lfsr[4:0];
      issue(a, b, lfsr[7], lfsr[7] ? "R2" : "R1");
    end

    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all results seen", 32'(exp_q.size()), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule